// File: doc/BRIEF.md
# NAND Flash Bus Interface Controller

This controller connects a host register port to a small-page NAND flash device. Software drives the flash control lines directly: it sets the command-latch, address-latch, chip-enable and write-unprotect bits in a mode register, one bit at a time with read-modify-write. Each command, address or data byte then passes through a single data register. Every data-register access produces one timed write or read strobe on the flash bus. A timing register sets the strobe low time and the hold time, and the host port stalls for the whole transfer.

A status register reports the flash busy state, taken from the ready/busy pin through a synchronizer. A reset register holds a self-clearing reset bit. A two-bit parity field in the mode register selects one of four actions: accumulate parity over the page bytes, clear the accumulator, read the parity back through the data register, or do nothing. The parity arithmetic is a placeholder: a rotating XOR across six parity bytes that covers one 512-byte page.

Top module: `nand_bus_ctrl`

## Requirements
- R1: Mode register (address 1) fields: bit 0 drives cle_o, bit 1 drives ale_o, bit 2 set drives ce_no low, and bit 3 drives wp_no directly. The register reads back as written, and it is 0 after reset.
- R2: Timing register (address 2) fields: bits [3:0] are the strobe width SPW and bits [7:4] are the hold time HOLD. Its reset value is 0x13. A data-register (address 0) write pulls we_no low for exactly SPW+1 cycles. A data-register read does the same on re_no.
- R3: After an accepted data access, stall_o stays high for SPW+HOLD+2 cycles. Any request made while stall_o is high is ignored.
- R4: During a write strobe, io_oe_o is high and io_o carries the written byte. A read captures io_i at the end of the strobe, and rdata_o holds that byte once stall_o falls.
- R5: Status register (address 3) bit 0 reads 1 while rb_ni is low. The value passes through a two-flop synchronizer, so a read issued in the cycle after rb_ni falls still returns 0.
- R6: Writing 1 to bit 0 of the reset register (address 4) makes that bit read 1 for RST_CYCLES cycles, after which it clears. While it is set, host writes and data strobes are ignored. The mode register ends at 0, the timing register ends at 0x13, and the parity state is cleared.
- R7: Mode bits [6:5] hold the parity field: 0 off, 1 accumulate, 2 readout, 3 clear. While the field holds 3, all parity bytes are 0.
- R8: In accumulate mode, the n-th transferred byte (write or read) is XORed into parity byte n mod 6. Only the first PAGE_BYTES bytes after a clear are counted.
- R9: In readout mode, a data read returns parity byte k with no strobe and no stall, and k advances 0..5 and then wraps to 0. k returns to 0 whenever the field leaves readout.
- R10: Mode bit 4 selects the separated bus configuration and appears on bus_split_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host request, one cycle |
| we_i | input | 1 | Host write (1) or read (0) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, registered |
| stall_o | output | 1 | Transfer in progress; requests ignored |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| ce_no | output | 1 | Chip enable, active low |
| wp_no | output | 1 | Write protect, active low |
| we_no | output | 1 | Write strobe, active low |
| re_no | output | 1 | Read strobe, active low |
| io_i | input | 8 | Flash data in |
| io_o | output | 8 | Flash data out |
| io_oe_o | output | 1 | Flash data output enable |
| rb_ni | input | 1 | Flash ready/busy, low = busy |
| bus_split_o | output | 1 | Separated bus configuration |

## Verification
The in-line assertions check four things on every cycle. A strobe never stays low longer than the width latched at its start. A started transfer always raises the stall. The mode register never moves while a transfer is under way. The parity readout index stays in range, falls to zero outside readout, and the page byte count never passes the page size. Only the bench scenarios can show the exact strobe and stall lengths for each timing setting, the bytes seen on the flash bus, the synchronizer delay, the parity values, the readout order and wrap, the page limit, and the way the reset bit clears the registers while blocking writes.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  typedef enum logic [2:0] {
    ADDR_DATA   = 3'd0,
    ADDR_MODE   = 3'd1,
    ADDR_TIMING = 3'd2,
    ADDR_STATUS = 3'd3,
    ADDR_RESET  = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    ECC_OFF   = 2'd0,
    ECC_CALC  = 2'd1,
    ECC_READ  = 2'd2,
    ECC_CLEAR = 2'd3
  } ecc_mode_e;

  typedef struct packed {
    ecc_mode_e ecc;
    logic      split;
    logic      wr_en;
    logic      ce;
    logic      ale;
    logic      cle;
  } mode_t;
endpackage

// File: rtl/nbc_sync.sv
module nbc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/nbc_regs.sv
module nbc_regs
  import nbc_pkg::*;
#(
  parameter int         RST_CYCLES = 8,
  parameter logic [7:0] TIMING_RST = 8'h13,
  parameter int         TW         = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  reg_addr_e     addr_i,
  input  logic [7:0]    wdata_i,
  output mode_t         mode_o,
  output logic [TW-1:0] spw_o,
  output logic [TW-1:0] hold_o,
  output logic          rst_busy_o
);
  localparam int RCW = $clog2(RST_CYCLES + 1);

  mode_t          mode_q;
  logic [2*TW-1:0] timing_q;
  logic           busy_q;
  logic [RCW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      timing_q <= TIMING_RST;
      busy_q   <= 1'b0;
      cnt_q    <= '0;
    end else if (busy_q) begin
      mode_q   <= '0;
      timing_q <= TIMING_RST;
      cnt_q    <= cnt_q + 1'b1;
      if (cnt_q == RCW'(RST_CYCLES - 1)) busy_q <= 1'b0;
    end else if (wr_i) begin
      case (addr_i)
        ADDR_MODE:   mode_q   <= mode_t'(wdata_i[6:0]);
        ADDR_TIMING: timing_q <= wdata_i;
        ADDR_RESET: if (wdata_i[0]) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
        end
        default: ;
      endcase
    end
  end

  assign mode_o     = mode_q;
  assign spw_o      = timing_q[TW-1:0];
  assign hold_o     = timing_q[2*TW-1:TW];
  assign rst_busy_o = busy_q;

  // R6
  rst_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> (mode_q == '0 && timing_q == TIMING_RST));
endmodule

// File: rtl/nbc_strobe.sv
module nbc_strobe #(
  parameter int TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rd_i,
  input  logic [7:0]    wdata_i,
  input  logic [TW-1:0] spw_i,
  input  logic [TW-1:0] hold_i,
  input  logic [7:0]    io_i,
  output logic          we_no,
  output logic          re_no,
  output logic [7:0]    io_o,
  output logic          io_oe_o,
  output logic          busy_o,
  output logic          byte_v_o,
  output logic          rd_v_o,
  output logic [7:0]    byte_o
);
  typedef enum logic [1:0] {S_IDLE, S_STRB, S_HOLD} st_e;

  st_e           st_q;
  logic [TW-1:0] cnt_q, spw_q, hold_q;
  logic          rd_q, byte_v_q, rd_v_q;
  logic [7:0]    wd_q, byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; cnt_q <= '0; spw_q <= '0; hold_q <= '0;
      rd_q <= 1'b0; wd_q <= '0; byte_q <= '0; byte_v_q <= 1'b0; rd_v_q <= 1'b0;
    end else begin
      byte_v_q <= 1'b0;
      rd_v_q   <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          st_q <= S_STRB; cnt_q <= '0;
          spw_q <= spw_i; hold_q <= hold_i;
          rd_q <= rd_i; wd_q <= wdata_i;
        end
        S_STRB: if (cnt_q == spw_q) begin
          st_q     <= S_HOLD;
          cnt_q    <= '0;
          byte_v_q <= 1'b1;
          rd_v_q   <= rd_q;
          byte_q   <= rd_q ? io_i : wd_q;   // sample on strobe end
        end else cnt_q <= cnt_q + 1'b1;
        S_HOLD: if (cnt_q == hold_q) st_q <= S_IDLE;
                else cnt_q <= cnt_q + 1'b1;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign we_no    = !(st_q == S_STRB && !rd_q);
  assign re_no    = !(st_q == S_STRB && rd_q);
  assign io_o     = wd_q;
  assign io_oe_o  = (st_q != S_IDLE) && !rd_q;
  assign busy_o   = st_q != S_IDLE;
  assign byte_v_o = byte_v_q;
  assign rd_v_o   = rd_v_q;
  assign byte_o   = byte_q;

  // checker counter: cycles the strobe has already been low
  logic          strb_lo;
  logic [TW:0]   lo_cnt_q;
  assign strb_lo = !we_no || !re_no;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lo_cnt_q <= '0;
    else if (strb_lo) lo_cnt_q <= lo_cnt_q + 1'b1;
    else              lo_cnt_q <= '0;
  end

  // R2
  strobe_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_lo |-> (lo_cnt_q <= {1'b0, spw_q}));
  // R3
  stall_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
endmodule

// File: rtl/nbc_ecc.sv
module nbc_ecc
  import nbc_pkg::*;
#(
  parameter int PAGE_BYTES = 512,
  parameter int NPAR       = 6
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  ecc_mode_e mode_i,
  input  logic      byte_v_i,
  input  logic [7:0] byte_i,
  input  logic      rd_i,
  output logic [7:0] par_o
);
  localparam int LW = $clog2(NPAR);
  localparam int CW = $clog2(PAGE_BYTES + 1);

  logic [NPAR-1:0][7:0] par_q;
  logic [LW-1:0]        lane_q, idx_q;
  logic [CW-1:0]        cnt_q;
  logic                 wipe, acc;

  assign wipe = clr_i || mode_i == ECC_CLEAR;
  assign acc  = mode_i == ECC_CALC && byte_v_i && cnt_q < CW'(PAGE_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_q <= '0; lane_q <= '0; cnt_q <= '0;
    end else if (wipe) begin
      par_q <= '0; lane_q <= '0; cnt_q <= '0;
    end else if (acc) begin
      for (int i = 0; i < NPAR; i++)
        if (lane_q == LW'(i)) par_q[i] <= par_q[i] ^ byte_i;
      lane_q <= (lane_q == LW'(NPAR - 1)) ? '0 : lane_q + 1'b1;
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          idx_q <= '0;
    else if (clr_i || mode_i != ECC_READ) idx_q <= '0;
    else if (rd_i) idx_q <= (idx_q == LW'(NPAR - 1)) ? '0 : idx_q + 1'b1;
  end

  assign par_o = par_q[idx_q];

  // R9
  ecc_idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q < LW'(NPAR));
  // R9
  ecc_idx_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != ECC_READ) |=> idx_q == '0);
  // R8
  ecc_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(PAGE_BYTES));
endmodule

// File: rtl/nand_bus_ctrl.sv
module nand_bus_ctrl
  import nbc_pkg::*;
#(
  parameter int         PAGE_BYTES  = 512,
  parameter int         ECC_BYTES   = 6,
  parameter int         RST_CYCLES  = 8,
  parameter logic [7:0] TIMING_RST  = 8'h13,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       we_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       stall_o,
  output logic       cle_o,
  output logic       ale_o,
  output logic       ce_no,
  output logic       wp_no,
  output logic       we_no,
  output logic       re_no,
  input  logic [7:0] io_i,
  output logic [7:0] io_o,
  output logic       io_oe_o,
  input  logic       rb_ni,
  output logic       bus_split_o
);
  localparam int TW = 4;

  reg_addr_e     addr;
  mode_t         mode;
  logic [TW-1:0] spw, hold;
  logic          rst_busy, rb_sync, busy_flag;
  logic          acc, is_data, ecc_rd_mode, start, ecc_rd, reg_wr;
  logic          byte_v, rd_v;
  logic [7:0]    byte_cap, par_byte, rdata_q;

  assign addr        = reg_addr_e'(addr_i);
  assign acc         = req_i && !stall_o;
  assign is_data     = addr == ADDR_DATA;
  assign ecc_rd_mode = mode.ecc == ECC_READ;
  assign start  = acc && is_data && !rst_busy && !(!we_i && ecc_rd_mode);
  assign ecc_rd = acc && is_data && !we_i && ecc_rd_mode && !rst_busy;
  assign reg_wr = acc && we_i && !is_data;

  nbc_regs #(.RST_CYCLES(RST_CYCLES), .TIMING_RST(TIMING_RST), .TW(TW)) i_regs (
    .clk_i, .rst_ni, .wr_i(reg_wr), .addr_i(addr), .wdata_i,
    .mode_o(mode), .spw_o(spw), .hold_o(hold), .rst_busy_o(rst_busy)
  );

  nbc_strobe #(.TW(TW)) i_strobe (
    .clk_i, .rst_ni, .start_i(start), .rd_i(!we_i), .wdata_i,
    .spw_i(spw), .hold_i(hold), .io_i,
    .we_no, .re_no, .io_o, .io_oe_o, .busy_o(stall_o),
    .byte_v_o(byte_v), .rd_v_o(rd_v), .byte_o(byte_cap)
  );

  nbc_ecc #(.PAGE_BYTES(PAGE_BYTES), .NPAR(ECC_BYTES)) i_ecc (
    .clk_i, .rst_ni, .clr_i(rst_busy), .mode_i(mode.ecc),
    .byte_v_i(byte_v), .byte_i(byte_cap), .rd_i(ecc_rd), .par_o(par_byte)
  );

  nbc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_rb_sync (
    .clk_i, .rst_ni, .d_i(rb_ni), .q_o(rb_sync)
  );
  assign busy_flag = !rb_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (acc && !we_i) begin
      case (addr)
        ADDR_MODE:   rdata_q <= {1'b0, mode};
        ADDR_TIMING: rdata_q <= {hold, spw};
        ADDR_STATUS: rdata_q <= {7'b0, busy_flag};
        ADDR_RESET:  rdata_q <= {7'b0, rst_busy};
        ADDR_DATA:   if (ecc_rd) rdata_q <= par_byte;
        default:     rdata_q <= '0;
      endcase
    end else if (rd_v) rdata_q <= byte_cap;
  end

  assign rdata_o     = rdata_q;
  assign cle_o       = mode.cle;
  assign ale_o       = mode.ale;
  assign ce_no       = !mode.ce;
  assign wp_no       = mode.wr_en;
  assign bus_split_o = mode.split;

  // R3
  stall_mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !rst_busy) |=> $stable(mode));
endmodule

// File: tb/test_nand_bus_ctrl.sv
module test_nand_bus_ctrl;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       req = 1'b0, we = 1'b0, rb_ni = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, io_i = '0;
  logic [7:0] rdata_o, io_o;
  logic       stall_o, cle_o, ale_o, ce_no, wp_no, we_no, re_no, io_oe_o, bus_split_o;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  nand_bus_ctrl i_nand_bus_ctrl (
    .clk_i(clk), .rst_ni, .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o, .stall_o, .cle_o, .ale_o, .ce_no, .wp_no, .we_no, .re_no,
    .io_i, .io_o, .io_oe_o, .rb_ni, .bus_split_o
  );

  // {spw, hold, write byte, read byte}
  localparam logic [23:0] VEC [4] = '{
    {4'd0, 4'd0, 8'hA5, 8'h3C},
    {4'd3, 4'd1, 8'h5A, 8'hC3},
    {4'd7, 4'd2, 8'hFF, 8'h01},
    {4'd15, 4'd15, 8'h00, 8'h80}
  };

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic [2:0] a, input logic [7:0] d,
                    output logic [7:0] rd, output int we_lo, output int re_lo,
                    output int st_n, output bit bus_ok);
    @(negedge clk); req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk); req = 1'b0;
    we_lo = 0; re_lo = 0; st_n = 0; bus_ok = 1;
    while (stall_o) begin
      st_n++;
      if (!we_no) begin
        we_lo++;
        if (!(io_oe_o && io_o == d)) bus_ok = 0;
      end
      if (!re_no) re_lo++;
      @(negedge clk);
    end
    rd = rdata_o;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] r; int x, y, z; bit b;
    op(1'b1, a, d, r, x, y, z, b);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] r);
    int x, y, z; bit b;
    op(1'b0, a, 8'h00, r, x, y, z, b);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] r, m;
    logic [7:0] par [6];
    int wl, rl, sn; bit ok;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // reset state
    chk(cle_o == 0 && ale_o == 0 && ce_no == 1 && wp_no == 0, "R1 reset lines", {cle_o, ale_o, ce_no, wp_no}, 4'b0010);
    chk(we_no && re_no && !stall_o && !io_oe_o, "R2 reset strobes idle", {we_no, re_no, stall_o}, 3'b110);
    rd(3'd1, r); chk(r == 8'h00, "R1 mode reset", r, 0);
    rd(3'd2, r); chk(r == 8'h13, "R2 timing reset", r, 8'h13);

    // R1 read-modify-write of control bits
    m = 8'h01; wr(3'd1, m);
    chk(cle_o == 1 && ale_o == 0 && ce_no == 1, "R1 cle only", {cle_o, ale_o, ce_no}, 3'b101);
    m = m | 8'h0E; wr(3'd1, m);
    chk(cle_o && ale_o && !ce_no && wp_no, "R1 all set", {cle_o, ale_o, ce_no, wp_no}, 4'b1101);
    rd(3'd1, r); chk(r == 8'h0F, "R1 readback", r, 8'h0F);
    m = m & ~8'h01; wr(3'd1, m);
    chk(!cle_o && ale_o, "R1 cle cleared", {cle_o, ale_o}, 2'b01);

    // R10
    wr(3'd1, m | 8'h10); chk(bus_split_o == 1, "R10 split set", bus_split_o, 1);
    wr(3'd1, m);         chk(bus_split_o == 0, "R10 split clear", bus_split_o, 0);

    // vector table: timing, write strobe, read strobe
    for (int i = 0; i < 4; i++) begin
      logic [3:0] spw, hld; logic [7:0] wb, rb;
      {spw, hld, wb, rb} = VEC[i];
      wr(3'd2, {hld, spw});
      op(1'b1, 3'd0, wb, r, wl, rl, sn, ok);
      chk(wl == spw + 1 && rl == 0, "R2 write strobe width", wl, spw + 1);
      chk(sn == spw + hld + 2, "R3 write stall length", sn, spw + hld + 2);
      chk(ok, "R4 write bus data", io_o, wb);
      io_i = rb;
      op(1'b0, 3'd0, 8'h00, r, wl, rl, sn, ok);
      chk(rl == spw + 1 && wl == 0, "R2 read strobe width", rl, spw + 1);
      chk(sn == spw + hld + 2, "R3 read stall length", sn, spw + hld + 2);
      chk(r == rb, "R4 read data", r, rb);
    end

    // R3 request during stall ignored
    wr(3'd2, 8'h55);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = 3'd0; wdata = 8'h99;
    @(negedge clk); addr = 3'd2; wdata = 8'h00;
    chk(stall_o == 1, "R3 stall raised", stall_o, 1);
    @(negedge clk); req = 1'b0;
    while (stall_o) @(negedge clk);
    rd(3'd2, r); chk(r == 8'h55, "R3 stalled write ignored", r, 8'h55);
    wr(3'd2, 8'h00);

    // R5 busy synchronizer
    @(negedge clk); rb_ni = 1'b0;
    rd(3'd3, r); chk(r == 8'h00, "R5 sync delay", r, 0);
    rd(3'd3, r); chk(r == 8'h01, "R5 busy seen", r, 1);
    rb_ni = 1'b1; repeat (3) @(negedge clk);
    rd(3'd3, r); chk(r == 8'h00, "R5 ready again", r, 0);

    // R7 R8 R9 parity accumulation and readout
    m = 8'h0C;
    wr(3'd1, m | 8'h60); wr(3'd1, m); wr(3'd1, m | 8'h20);
    for (int k = 0; k < 6; k++) par[k] = 8'h00;
    for (int k = 0; k < 8; k++) begin
      wr(3'd0, 8'(8'h11 * k + 3));
      par[k % 6] ^= 8'(8'h11 * k + 3);
    end
    io_i = 8'h5A; rd(3'd0, r); par[2] ^= 8'h5A;
    wr(3'd1, m | 8'h40);
    for (int k = 0; k < 6; k++) begin
      op(1'b0, 3'd0, 8'h00, r, wl, rl, sn, ok);
      chk(r == par[k], "R8 parity byte", r, par[k]);
      chk(rl == 0 && sn == 0, "R9 readout no strobe", rl, 0);
    end
    rd(3'd0, r); chk(r == par[0], "R9 index wrap", r, par[0]);
    rd(3'd0, r); chk(r == par[1], "R9 after wrap", r, par[1]);
    wr(3'd1, m); wr(3'd1, m | 8'h40);
    rd(3'd0, r); chk(r == par[0], "R9 index reset on leave", r, par[0]);
    wr(3'd1, m | 8'h60); wr(3'd1, m | 8'h40);
    rd(3'd0, r); chk(r == 8'h00, "R7 clear code", r, 0);

    // R8 page limit
    wr(3'd1, m | 8'h60); wr(3'd1, m | 8'h20);
    for (int k = 0; k < 6; k++) par[k] = 8'h00;
    for (int k = 0; k < 512; k++) begin
      wr(3'd0, 8'(k));
      par[k % 6] ^= 8'(k);
    end
    for (int k = 0; k < 6; k++) wr(3'd0, 8'hFF);
    wr(3'd1, m | 8'h40);
    for (int k = 0; k < 6; k++) begin
      rd(3'd0, r); chk(r == par[k], "R8 page limit", r, par[k]);
    end

    // R6 self-clearing reset
    wr(3'd1, 8'h0F); wr(3'd2, 8'h77);
    wr(3'd4, 8'h01);
    rd(3'd4, r); chk(r == 8'h01, "R6 reset bit set", r, 1);
    wr(3'd2, 8'h22);
    op(1'b1, 3'd0, 8'h33, r, wl, rl, sn, ok);
    chk(wl == 0 && sn == 0, "R6 strobe blocked", wl, 0);
    repeat (10) @(negedge clk);
    rd(3'd4, r); chk(r == 8'h00, "R6 reset bit cleared", r, 0);
    rd(3'd1, r); chk(r == 8'h00, "R6 mode cleared", r, 0);
    rd(3'd2, r); chk(r == 8'h13, "R6 timing default", r, 8'h13);
    chk(!cle_o && ce_no && !wp_no, "R6 lines after reset", {cle_o, ce_no, wp_no}, 3'b010);
    wr(3'd1, 8'h40);
    rd(3'd0, r); chk(r == 8'h00, "R6 parity cleared", r, 0);

    finish_run();
  end
endmodule